// File: doc/BRIEF.md
# Image Sensor Readout Timing Generator

This block sequences the readout of a progressive-scan color pixel array whose physical area is larger than the window that carries picture data. A column counter sweeps every physical column once per line and a line counter steps down the array from top to bottom. Together they form the row read pointer, a mirrored or direct column address, and a qualifier that is high only inside the centred active window. A second pointer, the row reset pointer, runs ahead of the read pointer by a programmed number of lines. That lead sets the integration time of each row. A strobe output marks the span in which every active row is integrating at once, so that an external light source can fire then.

In master mode the block generates its own horizontal and vertical syncs, and the polarity of each is set by its own control bit. In slave mode the syncs are inputs. Their active edges restart the column count and either step or clear the line count. Lower frame rates keep the line period of the fastest rate and add whole blanking lines below the array. The frame length is the physical row count times a divisor taken from a 3-bit rate code. An active-low output enable gates the pixel qualifier and the pixel clock enable. An active-low power-down input freezes all timing state. Configuration is written through a small parallel write port.

Top module: `sensor_readout_tg`

## Requirements
- R1: While running in master mode, the physical column index advances by one per clock from 0 to PHYS_COLS-1 and then wraps to 0. At that wrap the line index `line_o` increments.
- R2: The frame length in lines is PHYS_ROWS times a divisor picked by the rate field. Rate codes 0..7 give divisors 1, 2, 3, 5, 6, 10, 15 and 30 (30, 15, 10, 6, 5, 3, 2 and 1 fps). The line index wraps to 0 after frame length minus one.
- R3: `pix_valid` is high only when the physical column lies in [H_OFF, H_OFF+ACT_COLS-1] and the line lies in [V_OFF, V_OFF+ACT_ROWS-1]. Here H_OFF = (PHYS_COLS-ACT_COLS)/2 and V_OFF = (PHYS_ROWS-ACT_ROWS)/2. It is never high on the added blanking lines.
- R4: With the mirror bit (control bit 0) set, `col_addr` equals PHYS_COLS-1 minus the physical column. With the bit clear it equals the physical column.
- R5: The horizontal sync is active for the first HSYNC_W columns of each line. The vertical sync is active for all of line 0. Control bit 1 (horizontal) and control bit 2 (vertical) select active-high when 1 and active-low when 0. `sync_oe` follows `master_mode`.
- R6: In slave mode an active edge on `hsync_in` puts the column at 0 and advances the line on the next clock. An active edge on `vsync_in` puts both the column and the line at 0, and wins over `hsync_in`. The input polarities follow the same control bits as in R5. Without an edge the column holds at PHYS_COLS-1.
- R7: `rst_line_o` equals (line + E) mod frame length. E is the exposure register, read as 1 when it is 0 and limited to the frame length when it is larger.
- R8: While `out_en_n` is high, `pix_valid` and `pclk_en` are both low.
- R9: While `pwr_dn_n` is low, the counters and the strobe hold their values and `pclk_en` is low.
- R10: When control bit 3 is set and E >= ACT_ROWS, `flash` rises on the clock after a line start (column 0) on which `rst_line_o` equals the last active row. It falls on the clock after a cycle whose line equals V_OFF.
- R11: A write to address 0 loads the control field: bit 0 mirror, bit 1 horizontal polarity, bit 2 vertical polarity, bit 3 strobe enable, bits 6:4 rate. A write to address 1 loads the exposure. Writes to addresses 2 and 3 change nothing. After reset the control field is 0 and the exposure is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn_n | input | 1 | Power-down, active low; freezes timing |
| out_en_n | input | 1 | Output enable, active low |
| master_mode | input | 1 | 1: generate syncs, 0: follow sync inputs |
| hsync_in | input | 1 | External horizontal sync (slave mode) |
| vsync_in | input | 1 | External vertical sync (slave mode) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address |
| cfg_wdata | input | EXP_W | Configuration write data |
| col_addr | output | COL_W | Column address, mirrored when selected |
| line_o | output | LINE_W | Row read pointer (line within frame) |
| rst_line_o | output | LINE_W | Row reset pointer |
| pix_valid | output | 1 | Active-window pixel qualifier |
| pclk_en | output | 1 | Pixel clock enable |
| hsync_out | output | 1 | Generated horizontal sync |
| vsync_out | output | 1 | Generated vertical sync |
| sync_oe | output | 1 | Drive enable for the sync pins |
| flash | output | 1 | Light strobe |

## Verification
The column and line counters, the sync edge detectors and the strobe are registers, so their effects appear one rising edge after the cause. A slave sync edge shows as column 0 right after the edge that sampled it. A write changes the outputs decoded from the registers immediately after its edge. That edge still advances the counters under the old settings. The column address, the syncs, the qualifier and the reset pointer are decoded combinationally from that state, so they are valid in the same cycle. The bench drives inputs on falling edges and samples 1 ns after each rising edge. It keeps an exact count of edges since reset, or seeks a known column and line, so that every expected value is tied to a known position in the frame.

// File: rtl/stg_pkg.sv
package stg_pkg;

   typedef enum logic [2:0] {
      RATE_30 = 3'd0,
      RATE_15 = 3'd1,
      RATE_10 = 3'd2,
      RATE_6  = 3'd3,
      RATE_5  = 3'd4,
      RATE_3  = 3'd5,
      RATE_2  = 3'd6,
      RATE_1  = 3'd7
   } rate_e;

   // field order fixes the write-data bit positions
   typedef struct packed {
      rate_e rate;      // [6:4]
      logic  flash_en;  // [3]
      logic  vs_pol;    // [2]
      logic  hs_pol;    // [1]
      logic  mirror;    // [0]
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   function automatic int unsigned rate_div(rate_e r);
      case (r)
         RATE_30: return 1;
         RATE_15: return 2;
         RATE_10: return 3;
         RATE_6:  return 5;
         RATE_5:  return 6;
         RATE_3:  return 10;
         RATE_2:  return 15;
         default: return 30;
      endcase
   endfunction

endpackage

// File: rtl/stg_cfg_regs.sv
module stg_cfg_regs
   import stg_pkg::*;
#(
   parameter int EXP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       addr,
   input  logic [EXP_W-1:0] wdata,
   output ctrl_t            ctrl,
   output logic [EXP_W-1:0] exposure
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         exposure <= EXP_W'(1);
      end else if (we) begin
         if (addr == 2'd0) ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (addr == 2'd1) exposure <= wdata;
      end
   end

endmodule

// File: rtl/stg_scan_counter.sv
module stg_scan_counter #(
   parameter int PHYS_COLS = 362,
   parameter int COL_W     = 9,
   parameter int LINE_W    = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              master,
   input  logic              h_edge,
   input  logic              v_edge,
   input  logic [LINE_W-1:0] frame_len,
   output logic [COL_W-1:0]  col_q,
   output logic [LINE_W-1:0] line_q
);

   localparam logic [COL_W-1:0] COL_LAST = COL_W'(PHYS_COLS - 1);

   logic [LINE_W-1:0] line_nx;

   always_comb begin
      if (line_q >= frame_len - LINE_W'(1)) line_nx = '0;
      else                                  line_nx = line_q + LINE_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         line_q <= '0;
      end else if (run) begin
         if (!master && v_edge) begin
            col_q  <= '0;
            line_q <= '0;
         end else if (!master && h_edge) begin
            col_q  <= '0;
            line_q <= line_nx;
         end else if (col_q == COL_LAST) begin
            if (master) begin
               col_q  <= '0;
               line_q <= line_nx;
            end
         end else begin
            col_q <= col_q + COL_W'(1);
         end
      end
   end

endmodule

// File: rtl/stg_expo_flash.sv
module stg_expo_flash #(
   parameter int LINE_W    = 14,
   parameter int EXP_W     = 16,
   parameter int ACT_ROWS  = 288,
   parameter int FIRST_ROW = 5,
   parameter int LAST_ROW  = 292
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              col_zero,
   input  logic              flash_en,
   input  logic [LINE_W-1:0] line,
   input  logic [LINE_W-1:0] frame_len,
   input  logic [EXP_W-1:0]  exposure,
   output logic [LINE_W-1:0] rst_line,
   output logic              flash
);

   localparam int SW = ((EXP_W > LINE_W) ? EXP_W : LINE_W) + 1;

   logic [SW-1:0] exp_w, len_w, e_eff, sum, wrapped;
   logic          set_c, clr_c;

   always_comb begin
      exp_w = SW'(exposure);
      len_w = SW'(frame_len);
      if (exp_w == '0)        e_eff = SW'(1);
      else if (exp_w > len_w) e_eff = len_w;
      else                    e_eff = exp_w;
      sum = SW'(line) + e_eff;
      if (sum >= len_w) wrapped = sum - len_w;
      else              wrapped = sum;
   end

   assign rst_line = LINE_W'(wrapped);

   assign set_c = run && col_zero && flash_en &&
                  (e_eff >= SW'(ACT_ROWS)) && (rst_line == LINE_W'(LAST_ROW));
   assign clr_c = run && (line == LINE_W'(FIRST_ROW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flash <= 1'b0;
      else if (set_c) flash <= 1'b1;
      else if (clr_c) flash <= 1'b0;
   end

endmodule

// File: rtl/sensor_readout_tg.sv
module sensor_readout_tg
   import stg_pkg::*;
#(
   parameter int  PHYS_COLS = 362,
   parameter int  PHYS_ROWS = 298,
   parameter int  ACT_COLS  = 352,
   parameter int  ACT_ROWS  = 288,
   parameter int  HSYNC_W   = 16,
   parameter int  EXP_W     = 16,
   parameter bit  MIRROR_EN = 1'b1,
   localparam int COL_W     = $clog2(PHYS_COLS),
   localparam int LINE_W    = $clog2(PHYS_ROWS * 30 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn_n,
   input  logic              out_en_n,
   input  logic              master_mode,
   input  logic              hsync_in,
   input  logic              vsync_in,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [EXP_W-1:0]  cfg_wdata,
   output logic [COL_W-1:0]  col_addr,
   output logic [LINE_W-1:0] line_o,
   output logic [LINE_W-1:0] rst_line_o,
   output logic              pix_valid,
   output logic              pclk_en,
   output logic              hsync_out,
   output logic              vsync_out,
   output logic              sync_oe,
   output logic              flash
);

   localparam int H_OFF  = (PHYS_COLS - ACT_COLS) / 2;
   localparam int V_OFF  = (PHYS_ROWS - ACT_ROWS) / 2;
   localparam int H_LAST = H_OFF + ACT_COLS - 1;
   localparam int V_LAST = V_OFF + ACT_ROWS - 1;

   // elaboration-time parameter checks
   if (ACT_COLS < 1 || ACT_COLS > PHYS_COLS) begin : g_bad_cols
      $error("ACT_COLS must lie in 1..PHYS_COLS");
   end
   if (ACT_ROWS < 1 || ACT_ROWS > PHYS_ROWS) begin : g_bad_rows
      $error("ACT_ROWS must lie in 1..PHYS_ROWS");
   end
   if (HSYNC_W < 1 || HSYNC_W >= PHYS_COLS) begin : g_bad_hsw
      $error("HSYNC_W must lie in 1..PHYS_COLS-1");
   end
   if (EXP_W < CTRL_W) begin : g_bad_expw
      $error("EXP_W too narrow for the control field");
   end

   ctrl_t             ctrl;
   logic [EXP_W-1:0]  exposure;
   logic [LINE_W-1:0] frame_len;
   logic [COL_W-1:0]  col_q;
   logic [LINE_W-1:0] line_q;
   logic              run;
   logic [1:0]        sync_v, pol_v, edge_v;

   assign run = pwr_dn_n;

   stg_cfg_regs #(.EXP_W(EXP_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .ctrl     (ctrl),
      .exposure (exposure)
   );

   assign frame_len = LINE_W'(PHYS_ROWS * rate_div(ctrl.rate));

   // sync input edge detectors: index 0 horizontal, 1 vertical
   assign sync_v = {vsync_in, hsync_in};
   assign pol_v  = {ctrl.vs_pol, ctrl.hs_pol};

   for (genvar i = 0; i < 2; i++) begin : g_edge
      logic act, prev;
      assign act = pol_v[i] ? sync_v[i] : ~sync_v[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   prev <= 1'b1;
         else if (run) prev <= act;
      end
      assign edge_v[i] = act & ~prev;
   end

   stg_scan_counter #(
      .PHYS_COLS (PHYS_COLS),
      .COL_W     (COL_W),
      .LINE_W    (LINE_W)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .master    (master_mode),
      .h_edge    (edge_v[0]),
      .v_edge    (edge_v[1]),
      .frame_len (frame_len),
      .col_q     (col_q),
      .line_q    (line_q)
   );

   stg_expo_flash #(
      .LINE_W    (LINE_W),
      .EXP_W     (EXP_W),
      .ACT_ROWS  (ACT_ROWS),
      .FIRST_ROW (V_OFF),
      .LAST_ROW  (V_LAST)
   ) u_expo (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .col_zero  (col_q == '0),
      .flash_en  (ctrl.flash_en),
      .line      (line_q),
      .frame_len (frame_len),
      .exposure  (exposure),
      .rst_line  (rst_line_o),
      .flash     (flash)
   );

   if (MIRROR_EN) begin : g_mirror
      assign col_addr = ctrl.mirror ? (COL_W'(PHYS_COLS - 1) - col_q) : col_q;
   end else begin : g_direct
      assign col_addr = col_q;
   end

   logic in_h, in_v, hs_act, vs_act;

   assign in_h   = (col_q >= COL_W'(H_OFF)) && (col_q <= COL_W'(H_LAST));
   assign in_v   = (line_q >= LINE_W'(V_OFF)) && (line_q <= LINE_W'(V_LAST));
   assign hs_act = col_q < COL_W'(HSYNC_W);
   assign vs_act = line_q == '0;

   assign line_o    = line_q;
   assign pix_valid = in_h && in_v && run && !out_en_n;
   assign pclk_en   = run && !out_en_n;
   assign hsync_out = ctrl.hs_pol ? hs_act : ~hs_act;
   assign vsync_out = ctrl.vs_pol ? vs_act : ~vs_act;
   assign sync_oe   = master_mode;

endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
   parameter int PHYS_COLS = 362,
   parameter int PHYS_ROWS = 298,
   parameter int V_OFF     = 5,
   parameter int COL_W     = 9,
   parameter int LINE_W    = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_dn_n,
   input logic              out_en_n,
   input logic              master_mode,
   input logic [COL_W-1:0]  col_q,
   input logic [LINE_W-1:0] line_q,
   input logic [LINE_W-1:0] frame_len,
   input logic [LINE_W-1:0] rst_line_o,
   input logic              pix_valid,
   input logic              pclk_en,
   input logic              flash
);

   assert_col_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= COL_W'(PHYS_COLS - 1));

   assert_col_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_dn_n && master_mode && col_q != COL_W'(PHYS_COLS - 1))
      |=> col_q == $past(col_q) + COL_W'(1));

   assert_line_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(frame_len) && $past(line_q) < $past(frame_len)) |-> line_q < frame_len);

   assert_no_blank_pix_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> line_q < LINE_W'(PHYS_ROWS));

   assert_rst_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q < frame_len) |-> rst_line_o < frame_len);

   assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> (!pix_valid && !pclk_en));

   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |=> ($stable(col_q) && $stable(line_q) && $stable(flash)));

   assert_flash_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flash) |-> $past(line_q) == LINE_W'(V_OFF));

endmodule

bind sensor_readout_tg stg_checker #(
   .PHYS_COLS (PHYS_COLS),
   .PHYS_ROWS (PHYS_ROWS),
   .V_OFF     (V_OFF),
   .COL_W     (COL_W),
   .LINE_W    (LINE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_dn_n    (pwr_dn_n),
   .out_en_n    (out_en_n),
   .master_mode (master_mode),
   .col_q       (col_q),
   .line_q      (line_q),
   .frame_len   (frame_len),
   .rst_line_o  (rst_line_o),
   .pix_valid   (pix_valid),
   .pclk_en     (pclk_en),
   .flash       (flash)
);

// File: tb/tb_sensor_readout_tg.sv
`timescale 1ns/1ps
module tb_sensor_readout_tg;

   localparam int PC = 12;
   localparam int PR = 10;
   localparam int AC = 8;
   localparam int AR = 6;
   localparam int HW = 2;
   localparam int EW = 16;
   localparam int CW = $clog2(PC);
   localparam int LW = $clog2(PR * 30 + 1);
   localparam int HOFF = (PC - AC) / 2;
   localparam int VOFF = (PR - AR) / 2;

   logic clk = 1'b0;
   logic rst_n, pwr_dn_n, out_en_n, master_mode, hsync_in, vsync_in, cfg_we;
   logic [1:0]    cfg_addr;
   logic [EW-1:0] cfg_wdata;
   logic [CW-1:0] col_addr;
   logic [LW-1:0] line_o, rst_line_o;
   logic pix_valid, pclk_en, hsync_out, vsync_out, sync_oe, flash;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sensor_readout_tg #(
      .PHYS_COLS (PC), .PHYS_ROWS (PR), .ACT_COLS (AC), .ACT_ROWS (AR),
      .HSYNC_W (HW), .EXP_W (EW), .MIRROR_EN (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .pwr_dn_n (pwr_dn_n), .out_en_n (out_en_n),
      .master_mode (master_mode), .hsync_in (hsync_in), .vsync_in (vsync_in),
      .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
      .col_addr (col_addr), .line_o (line_o), .rst_line_o (rst_line_o),
      .pix_valid (pix_valid), .pclk_en (pclk_en), .hsync_out (hsync_out),
      .vsync_out (vsync_out), .sync_oe (sync_oe), .flash (flash)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   // leaves the bench one edge after reset release (column 1)
   task automatic do_reset(input logic master);
      rst_n = 1'b0; pwr_dn_n = 1'b1; out_en_n = 1'b0; master_mode = master;
      hsync_in = 1'b1; vsync_in = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = EW'(d);
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
   endtask

   task automatic seek(input int c, input int l, input string req);
      int guard = 0;
      while (!(int'(col_addr) == c && int'(line_o) == l) && guard < 20000) begin
         tick();
         guard++;
      end
      if (guard >= 20000) chk(req, guard, -1);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; pwr_dn_n = 1'b1; out_en_n = 1'b0; master_mode = 1'b1;
      hsync_in = 1'b1; vsync_in = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 reset col", int'(col_addr), 0);
      chk("R1 reset line", int'(line_o), 0);
      chk("R3 reset pix_valid", int'(pix_valid), 0);
      chk("R10 reset flash", int'(flash), 0);
      chk("R11 reset exposure 1 gives rst_line", int'(rst_line_o), 1);
      chk("R5 reset hsync active-low", int'(hsync_out), 0);
      chk("R5 reset vsync active-low", int'(vsync_out), 0);
      chk("R5 sync_oe master", int'(sync_oe), 1);
   endtask

   task automatic t_scan;
      do_reset(1'b1);
      chk("R1 col after first edge", int'(col_addr), 1);
      tick(10);
      chk("R1 col at end of line", int'(col_addr), PC - 1);
      chk("R1 line before wrap", int'(line_o), 0);
      tick();
      chk("R1 col wraps", int'(col_addr), 0);
      chk("R1 line steps", int'(line_o), 1);
   endtask

   task automatic t_window;
      int act = 0, bad = 0;
      do_reset(1'b1);
      for (int k = 0; k < PC * PR; k++) begin
         int c = int'(col_addr);
         int l = int'(line_o);
         bit e = (c >= HOFF) && (c < HOFF + AC) && (l >= VOFF) && (l < VOFF + AR);
         if (pix_valid) act++;
         if (pix_valid != e) bad++;
         tick();
      end
      chk("R3 active pixels per frame", act, AC * AR);
      chk("R3 window mismatches", bad, 0);
   endtask

   task automatic t_rate(input int code, input int div);
      int cyc = 0, maxl = 0, blank = 0;
      do_reset(1'b1);
      wr(0, code << 4);
      tick();
      seek(0, 0, "R2 seek frame start");
      tick();
      cyc = 1;
      while (!(col_addr == '0 && line_o == '0) && cyc < 20000) begin
         if (int'(line_o) > maxl) maxl = int'(line_o);
         if (pix_valid && int'(line_o) >= PR) blank++;
         tick();
         cyc++;
      end
      chk($sformatf("R2 frame cycles code %0d", code), cyc, PC * PR * div);
      chk($sformatf("R2 last line code %0d", code), maxl, PR * div - 1);
      chk($sformatf("R3 no pixels on blanking code %0d", code), blank, 0);
   endtask

   task automatic t_mirror;
      do_reset(1'b1);
      wr(0, 1);
      chk("R4 mirrored col 2", int'(col_addr), PC - 1 - 2);
      tick(3);
      chk("R4 mirrored col 5", int'(col_addr), PC - 1 - 5);
      wr(2, 0);
      chk("R11 write to address 2 ignored", int'(col_addr), PC - 1 - 6);
      wr(3, 16'hFFFF);
      chk("R11 write to address 3 ignored", int'(rst_line_o), int'(line_o) + 1);
      wr(0, 0);
      chk("R4 direct col", int'(col_addr), 8);
   endtask

   task automatic t_polarity;
      do_reset(1'b1);
      wr(0, 6);
      chk("R5 hsync inactive high-pol col 2", int'(hsync_out), 0);
      chk("R5 vsync active high-pol line 0", int'(vsync_out), 1);
      seek(0, 1, "R5 seek line 1");
      chk("R5 hsync active col 0", int'(hsync_out), 1);
      chk("R5 vsync inactive line 1", int'(vsync_out), 0);
      tick();
      chk("R5 hsync active col 1", int'(hsync_out), 1);
      tick();
      chk("R5 hsync inactive col 2", int'(hsync_out), 0);
   endtask

   task automatic t_expo;
      do_reset(1'b1);
      wr(1, 3);
      chk("R7 lead 3 at line 0", int'(rst_line_o), 3);
      seek(0, 8, "R7 seek line 8");
      chk("R7 lead 3 wraps", int'(rst_line_o), 1);
      wr(1, 0);
      chk("R7 zero exposure reads as 1", int'(rst_line_o), (int'(line_o) + 1) % PR);
      wr(1, 500);
      chk("R7 exposure limited to frame", int'(rst_line_o), int'(line_o));
   endtask

   task automatic t_oe;
      int seen = 0;
      do_reset(1'b1);
      @(negedge clk);
      out_en_n = 1'b1;
      for (int k = 0; k < PC * PR + 10; k++) begin
         tick();
         if (pix_valid || pclk_en) seen++;
      end
      chk("R8 outputs gated while disabled", seen, 0);
      @(negedge clk);
      out_en_n = 1'b0;
      #1;
      chk("R8 pclk_en back after enable", int'(pclk_en), 1);
   endtask

   task automatic t_pd;
      do_reset(1'b1);
      tick(4);
      @(negedge clk);
      pwr_dn_n = 1'b0;
      tick(20);
      chk("R9 col frozen", int'(col_addr), 5);
      chk("R9 line frozen", int'(line_o), 0);
      chk("R9 pclk_en low", int'(pclk_en), 0);
      @(negedge clk);
      pwr_dn_n = 1'b1;
      tick();
      chk("R9 resumes", int'(col_addr), 6);
   endtask

   task automatic t_slave;
      do_reset(1'b0);
      chk("R5 sync_oe low in slave", int'(sync_oe), 0);
      tick(20);
      chk("R6 col saturates", int'(col_addr), PC - 1);
      chk("R6 line held", int'(line_o), 0);
      @(negedge clk); hsync_in = 1'b0;
      tick();
      chk("R6 hsync edge col", int'(col_addr), 0);
      chk("R6 hsync edge line", int'(line_o), 1);
      tick(3);
      chk("R6 held level no edge", int'(col_addr), 3);
      @(negedge clk); hsync_in = 1'b1;
      tick();
      @(negedge clk); hsync_in = 1'b0; vsync_in = 1'b0;
      tick();
      chk("R6 vsync edge col", int'(col_addr), 0);
      chk("R6 vsync edge line", int'(line_o), 0);
      @(negedge clk); hsync_in = 1'b1; vsync_in = 1'b1;
      tick();
      @(negedge clk); hsync_in = 1'b0;
      tick();
      chk("R6 second hsync edge line", int'(line_o), 1);
      chk("R6 second hsync edge col", int'(col_addr), 0);
   endtask

   task automatic t_flash;
      int hi;
      do_reset(1'b1);
      wr(1, AR);
      wr(0, 8);
      tick();
      seek(0, 0, "R10 seek frame");
      hi = 0;
      for (int k = 0; k < PC * PR; k++) begin
         if (flash) hi++;
         if (k == PC)         chk("R10 low at set line start", int'(flash), 0);
         if (k == PC + 5)     chk("R10 high while all rows integrate", int'(flash), 1);
         if (k == 2 * PC)     chk("R10 high at first read line start", int'(flash), 1);
         if (k == 2 * PC + 1) chk("R10 low after readout starts", int'(flash), 0);
         tick();
      end
      chk("R10 strobe length", hi, PC);
      wr(1, AR - 1);
      tick();
      seek(0, 0, "R10 seek frame 2");
      hi = 0;
      for (int k = 0; k < PC * PR; k++) begin
         if (flash) hi++;
         tick();
      end
      chk("R10 no strobe when exposure short", hi, 0);
   endtask

   initial begin
      #(150000 * 5);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_scan();
      t_window();
      t_rate(1, 2);
      t_rate(3, 5);
      t_rate(7, 30);
      t_mirror();
      t_polarity();
      t_expo();
      t_oe();
      t_pd();
      t_slave();
      t_flash();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule